// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector for a GPIO Port

This block turns a vector of already-synchronized pin levels into per-pin pending flags and a single interrupt request. Each pin chooses on its own whether it reacts to a level or to a transition. It also chooses which polarity counts as active. In transition mode a pin can instead be told to react to changes in both directions, and its polarity setting is then ignored.

Pending flags are sticky. Software removes them by pulsing a clear strobe with a mask in which every 1 bit clears the matching flag. A pending flag is recorded whether or not the pin's interrupt is enabled. The enable vector only decides which pending flags reach the interrupt line. The interrupt line is the registered OR of pending-and-enabled over the whole port. Register decoding and pad control sit outside the block. The configuration vectors arrive as plain inputs.

Top module: `pinirq_detector`

## Requirements
- R1: After reset every pending flag reads 0 and the interrupt output is 0.
- R2: With a pin's trigger-select bit at 0 (level), the pending flag is set at the clock edge where the pin equals its polarity bit. A polarity of 1 makes high active and a polarity of 0 makes low active.
- R3: With the trigger-select bit at 1 (transition) and dual-direction off, the pending flag is set at the clock edge where the pin differs from its value at the previous edge. With polarity 1 only a 0-to-1 change counts, and with polarity 0 only a 1-to-0 change counts. The opposite change leaves the flag unchanged.
- R4: In transition mode with the dual-direction bit at 1, both kinds of change set the pending flag, whatever the polarity bit holds.
- R5: The dual-direction bit has no effect on a pin in level mode.
- R6: A clock edge that sees the clear strobe at 1 clears each pending flag whose mask bit is 1, provided no event hits it in the same cycle. Flags whose mask bit is 0 keep their value.
- R7: When an event and a clear reach the same flag at the same clock edge, the flag stays at 1.
- R8: A level-mode pin whose active level is still present cannot be cleared. The flag reads 1 again right after the clear.
- R9: Pending flags are set and held regardless of the interrupt enable vector.
- R10: At each clock edge the interrupt output takes the OR over all pins of (pending flag AND enable bit), using the flags as they stood before that edge. It therefore rises one clock after a flag it depends on.
- R11: The first clock edge after reset release detects no transition, because no earlier sample exists to compare against.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Synchronized pin levels |
| trig_edge_i | input | NPINS | Trigger select per pin: 0 level, 1 transition |
| pol_high_i | input | NPINS | Polarity per pin: 1 high/rising, 0 low/falling |
| both_dir_i | input | NPINS | Dual-direction select per pin (transition mode only) |
| irq_en_i | input | NPINS | Per-pin interrupt enable |
| ack_stb_i | input | 1 | Clear strobe |
| ack_mask_i | input | NPINS | Write-one-to-clear mask, used while the strobe is 1 |
| pend_o | output | NPINS | Pending flags |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
The hardest situation to reach is a clear that meets a fresh event on the same flag in the same cycle. A flag that survives a clear could be a lost clear or a correct re-arm, and only a scoreboard that knows which cycle the event landed in can tell the two apart. The stimulus first sets a pin in dual-direction mode, then toggles it back in the very cycle it pulses the strobe on that bit. It separately holds a level-mode pin active while clearing it. A long pseudo-random run with mixed modes and random clear masks then puts many such collisions against a reference model.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

   typedef enum logic {
      TRIG_LEVEL = 1'b0,
      TRIG_EDGE  = 1'b1
   } trig_e;

   typedef struct packed {
      trig_e trig;
      logic  pol_high;
      logic  both_dir;
   } pin_cfg_t;

   localparam int unsigned MAX_PINS = 1024;

endpackage

// File: rtl/pinirq_trig.sv
module pinirq_trig
   import pinirq_pkg::*;
(
   input  pin_cfg_t cfg_i,
   input  logic     cur_i,
   input  logic     prev_i,
   input  logic     primed_i,
   output logic     hit_o
);

   logic rise, fall, lvl_hit, edge_hit;

   always_comb begin
      rise     = cur_i & ~prev_i;
      fall     = ~cur_i & prev_i;
      lvl_hit  = (cur_i == cfg_i.pol_high);
      if (cfg_i.both_dir)
         edge_hit = rise | fall;
      else if (cfg_i.pol_high)
         edge_hit = rise;
      else
         edge_hit = fall;
      edge_hit = edge_hit & primed_i;
      hit_o    = (cfg_i.trig == TRIG_EDGE) ? edge_hit : lvl_hit;
   end

endmodule

// File: rtl/pinirq_cell.sv
module pinirq_cell
   import pinirq_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  pin_cfg_t cfg_i,
   input  logic     pin_i,
   input  logic     primed_i,
   input  logic     clr_i,
   output logic     pend_o
);

   logic prev_q, pend_q, hit;

   pinirq_trig u_trig (
      .cfg_i    (cfg_i),
      .cur_i    (pin_i),
      .prev_i   (prev_q),
      .primed_i (primed_i),
      .hit_o    (hit)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= pin_i;
         pend_q <= hit | (pend_q & ~clr_i);
      end
   end

   assign pend_o = pend_q;

   a_r11_no_edge_unprimed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!primed_i && cfg_i.trig == TRIG_EDGE) |-> !hit);
   a_r6_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !hit) |=> !pend_q);
   a_r7_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit |=> pend_q);
   a_r3_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hit && !pend_q) |=> !pend_q);
   a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q && !clr_i) |=> pend_q);

endmodule

// File: rtl/pinirq_merge.sv
module pinirq_merge #(
   parameter int unsigned NPINS = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [NPINS-1:0] pend_i,
   input  logic [NPINS-1:0] en_i,
   output logic             irq_o
);

   logic irq_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= |(pend_i & en_i);
   end

   assign irq_o = irq_q;

   a_r10_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(pend_i & en_i)) |=> irq_o);
   a_r10_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_i == '0) |=> !irq_o);

endmodule

// File: rtl/pinirq_detector.sv
module pinirq_detector
   import pinirq_pkg::*;
#(
   parameter int unsigned NPINS = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [NPINS-1:0] pin_i,
   input  logic [NPINS-1:0] trig_edge_i,
   input  logic [NPINS-1:0] pol_high_i,
   input  logic [NPINS-1:0] both_dir_i,
   input  logic [NPINS-1:0] irq_en_i,
   input  logic             ack_stb_i,
   input  logic [NPINS-1:0] ack_mask_i,
   output logic [NPINS-1:0] pend_o,
   output logic             irq_o
);

   if (NPINS < 1 || NPINS > MAX_PINS) begin : g_bad_width
      $error("pinirq_detector: NPINS out of range");
   end

   logic             primed_q;
   logic [NPINS-1:0] clr_vec;
   logic [NPINS-1:0] pend;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) primed_q <= 1'b0;
      else         primed_q <= 1'b1;
   end

   assign clr_vec = ack_stb_i ? ack_mask_i : '0;

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      pin_cfg_t cfg;
      assign cfg.trig     = trig_edge_i[p] ? TRIG_EDGE : TRIG_LEVEL;
      assign cfg.pol_high = pol_high_i[p];
      assign cfg.both_dir = both_dir_i[p];

      pinirq_cell u_cell (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .cfg_i    (cfg),
         .pin_i    (pin_i[p]),
         .primed_i (primed_q),
         .clr_i    (clr_vec[p]),
         .pend_o   (pend[p])
      );
   end

   pinirq_merge #(.NPINS(NPINS)) u_merge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pend_i (pend),
      .en_i   (irq_en_i),
      .irq_o  (irq_o)
   );

   assign pend_o = pend;

   a_r1_primed_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> primed_q);

endmodule

// File: tb/pinirq_detector_tb_top.sv
`timescale 1ns/1ps
module pinirq_detector_tb_top;

   localparam int N = 32;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic         rst_n;
   logic [N-1:0] pin, emode, polh, dual, en, mask;
   logic         stb;
   logic [N-1:0] pend;
   logic         irq;

   pinirq_detector #(.NPINS(N)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .trig_edge_i(emode),
      .pol_high_i(polh), .both_dir_i(dual), .irq_en_i(en),
      .ack_stb_i(stb), .ack_mask_i(mask), .pend_o(pend), .irq_o(irq)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [N-1:0] m_stat, m_prev;
   logic         m_irq, m_vld;

   logic [N-1:0] stat_q[$];
   logic         irq_q[$];
   string        tag_q[$];

   task automatic chk(string tag, logic [N-1:0] es, logic ei);
      checks++;
      if (pend !== es || irq !== ei) begin
         fails++;
         $display("FAIL %s: pend=%h irq=%b, expected pend=%h irq=%b", tag, pend, irq, es, ei);
      end
   endtask

   // monitor: compares each expected item half a cycle after its clock edge
   always @(negedge clk) begin
      if (stat_q.size() > 0) begin
         logic [N-1:0] es;
         logic ei;
         string t;
         es = stat_q.pop_front();
         ei = irq_q.pop_front();
         t  = tag_q.pop_front();
         chk(t, es, ei);
      end
   end

   // driver: lets one clock edge pass, updates the model, queues the expectation
   task automatic step(string tag);
      logic [N-1:0] ev, clr;
      @(posedge clk);
      #1;
      for (int i = 0; i < N; i++) begin
         logic rise, fall;
         rise = pin[i] & ~m_prev[i];
         fall = ~pin[i] & m_prev[i];
         if (!emode[i])      ev[i] = (pin[i] == polh[i]);
         else if (!m_vld)    ev[i] = 1'b0;
         else if (dual[i])   ev[i] = rise | fall;
         else if (polh[i])   ev[i] = rise;
         else                ev[i] = fall;
      end
      clr    = stb ? mask : '0;
      m_irq  = |(m_stat & en);
      m_stat = ev | (m_stat & ~clr);
      m_prev = pin;
      m_vld  = 1'b1;
      stat_q.push_back(m_stat);
      irq_q.push_back(m_irq);
      tag_q.push_back(tag);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R1: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] x;
      rst_n = 1'b0;
      pin   = '0; pin[0] = 1'b1;
      emode = '1; polh = '1; dual = '0; en = '0;
      stb   = 1'b0; mask = '0;
      m_stat = '0; m_prev = '0; m_irq = 1'b0; m_vld = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1", '0, 1'b0);

      step("R11");                               // pin0 high since reset: no edge
      pin[1] = 1'b1;                 step("R3");   // rising, pol high
      stb = 1'b1; mask = 32'h2;      step("R6");
      stb = 1'b0;
      pin[1] = 1'b0;                 step("R3");   // falling ignored, pol high
      polh[2] = 1'b0; pin[2] = 1'b1; step("R3");   // rising ignored, pol low
      pin[2] = 1'b0;                 step("R3");   // falling sets
      dual[3] = 1'b1; pin[3] = 1'b1; step("R4");
      stb = 1'b1; mask = 32'h8;      step("R6");
      stb = 1'b0;
      pin[3] = 1'b0;                 step("R4");   // falling sets despite pol high
      emode[4] = 1'b0; dual[4] = 1'b1; pin[4] = 1'b0; step("R5");
      pin[4] = 1'b1;                 step("R5");
      stb = 1'b1; mask = 32'h10;     step("R8");   // level still high
      stb = 1'b0;
      dual[5] = 1'b1; pin[5] = 1'b1; step("R4");
      pin[5] = 1'b0; stb = 1'b1; mask = 32'h20; step("R7");
      mask = 32'h4;                  step("R6");   // bit2 cleared, others kept
      stb = 1'b0;
      step("R9");                                  // pending with enables off
      en[3] = 1'b1;                  step("R10");
      step("R10");
      stb = 1'b1; mask = 32'h8;      step("R10");
      stb = 1'b0;                    step("R10");
      step("R10");
      emode[6] = 1'b0; polh[6] = 1'b0; step("R2"); // low level active
      emode[7] = 1'b0; pin[7] = 1'b1;  step("R2"); // high level active
      en[7] = 1'b1;                  step("R10");
      step("R10");

      x = 32'h1234_5678;
      for (int k = 0; k < 60; k++) begin
         x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
         pin = x;
         if (k % 10 == 0) begin
            emode = x ^ 32'hA5A5_0F0F; polh = {x[15:0], x[31:16]};
            dual = x & 32'h0F0F_F0F0; en = ~x;
         end
         stb  = x[3];
         mask = {x[7:0], x[31:8]};
         step("R7");
      end
      stb = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule